// File: doc/BRIEF.md
# Non-volatile Byte Array Access Controller

This block sits on a small peripheral bus and gives a CPU byte access to a 512-entry non-volatile data array. Software loads a target byte address into a split address register, places a byte in a data register and then drives a control register. A read copies the addressed byte into the data register in a single cycle. A write copies the data register into the array only when a guarded two-step sequence is followed. First an arming bit opens a short time window, and hardware closes that window again on its own. The write command must land inside that window.

A write is a multi-cycle programming operation. The write command bit stays visible as set until programming completes, and hardware then clears it. The target address and byte are captured when programming begins, so software may change the registers at once without harming the write in flight. A level interrupt reports that the array is ready whenever it is enabled locally and globally and no write is running. The array is modelled as a register array with a fixed programming delay.

Register offsets on the 2-bit bus address: 0 control, 1 data, 2 address low byte, 3 address high byte. A bus read returns the selected register on `rd_data` one cycle after the read strobe.

Top module: `nvm_ctrl`

## Requirements
- R1: The byte address is ADDR_W (default 9) bits wide. The low byte holds address bits 7:0 and bit 0 of the high byte holds address bit 8. High-byte bits 7:1, which are address bits 15:9, always read as zero.
- R2: Control register layout: bit 3 ready-interrupt enable, bit 2 arm (master write enable), bit 1 write command / write busy, bit 0 read command. Bits 7:4 always read as zero.
- R3: Writing the control register with bit 2 set arms the controller for ARM_WINDOW (default 4) cycles. A write command at any of the next ARM_WINDOW clock edges is accepted. Bit 2 reads as one during that time and is then cleared by hardware.
- R4: A control write with bit 1 set while the controller is armed and idle stores the data register into the array at the current address.
- R5: A control write with bit 1 set while not armed, including one that sets bit 2 in the same write, has no effect. Bit 1 stays clear and the array keeps its old contents.
- R6: A control write with bit 0 set while idle loads the data register with the array byte at the current address, visible at the next bus read. Bit 0 always reads back as zero.
- R7: irq_o is a level equal to (ready-interrupt enable AND global_ie) while no write is in progress. It is low for the whole of a write.
- R8: After reset the data register, the control bits and irq_o are zero. The address register has no reset value.
- R9: After a write is accepted, control bit 1 reads as one for exactly PROG_CYCLES (default 64) cycles, and then reads as zero.
- R10: A read command issued while a write is in progress is ignored, and the data register keeps its value.
- R11: Changes to the address or data register during a write do not affect the byte being programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data, valid the cycle after bus_re |
| global_ie | input | 1 | Global interrupt enable from the CPU |
| irq_o | output | 1 | Ready interrupt, level |

## Verification
The hardest case to reach is the edge of the arming window. The write command must fall exactly on the last edge that is still accepted, and again on the first edge that is not. Each bus operation in the bench takes exactly one clock edge, so a counted number of idle edges between the arm and the command places the command on a chosen edge after arming. Protection of the latched write is reached by issuing address, data and read commands while the busy bit is still set, and then reading back the original location.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
   localparam int unsigned OFS_CTRL    = 0;
   localparam int unsigned OFS_DATA    = 1;
   localparam int unsigned OFS_ADDR_LO = 2;
   localparam int unsigned OFS_ADDR_HI = 3;
   localparam int unsigned CB_RD  = 0;
   localparam int unsigned CB_WR  = 1;
   localparam int unsigned CB_ARM = 2;
   localparam int unsigned CB_IEN = 3;
   localparam int unsigned BUS_W  = 8;
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock #(
   parameter int unsigned WINDOW = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   output logic open_o
);
   localparam int unsigned CW = $clog2(WINDOW + 1);
   logic [CW-1:0] cnt_q;

   generate if (WINDOW < 1) begin : g_bad_window
      $error("nvm_unlock: WINDOW must be at least 1");
   end endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (arm_i)         cnt_q <= CW'(WINDOW);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end
   assign open_o = (cnt_q != '0);

   // checker: age since last arm, saturating
   logic [CW:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         age_q <= '1;
      else if (arm_i)                     age_q <= '0;
      else if (age_q != '1)               age_q <= age_q + 1'b1;
   end

   // R3: window never outlives WINDOW cycles after arming
   a_r3_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
      open_o |-> (age_q < (CW+1)'(WINDOW)));
   // R3: arming opens the window at the next cycle
   a_r3_arm_opens: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> open_o);
endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq #(
   parameter int unsigned PROG_CYCLES = 64,
   parameter int unsigned ADDR_W      = 9,
   parameter int unsigned DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              busy_o,
   output logic              commit_o,
   output logic [ADDR_W-1:0] commit_addr_o,
   output logic [DATA_W-1:0] commit_data_o
);
   localparam int unsigned TW = $clog2(PROG_CYCLES + 1);
   logic [TW-1:0]     left_q;
   logic              busy_q;
   logic [ADDR_W-1:0] lat_addr_q;
   logic [DATA_W-1:0] lat_data_q;

   generate if (PROG_CYCLES < 2) begin : g_bad_prog
      $error("nvm_prog_seq: PROG_CYCLES must be at least 2");
   end endgenerate

   assign commit_o = busy_q && (left_q == TW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         left_q <= '0;
      end else if (start_i && !busy_q) begin
         busy_q <= 1'b1;
         left_q <= TW'(PROG_CYCLES);
      end else if (busy_q) begin
         left_q <= left_q - 1'b1;
         if (commit_o) busy_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (start_i && !busy_q) begin
         lat_addr_q <= addr_i;
         lat_data_q <= data_i;
      end
   end

   assign busy_o        = busy_q;
   assign commit_addr_o = lat_addr_q;
   assign commit_data_o = lat_data_q;

   // R9: busy holds until the final programming cycle
   a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !commit_o) |=> busy_q);
   // R9: busy drops right after commit
   a_r9_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> !busy_q);
   // R11: latched target stays put while programming
   a_r11_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> ($stable(lat_addr_q) && $stable(lat_data_q)));
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int unsigned DEPTH = 1 << ADDR_W;
   logic [DATA_W-1:0] cells_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) cells_q[waddr_i] <= wdata_i;
   end
   assign rdata_o = cells_q[raddr_i];
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
   import nvm_pkg::*;
#(
   parameter int unsigned ADDR_W      = 9,
   parameter int unsigned PROG_CYCLES = 64,
   parameter int unsigned ARM_WINDOW  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   input  logic             bus_we,
   input  logic             bus_re,
   output logic [BUS_W-1:0] rd_data,
   input  logic             global_ie,
   output logic             irq_o
);
   localparam int unsigned LO_W = (ADDR_W > 8) ? 8 : ADDR_W;

   generate if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("nvm_ctrl: ADDR_W must be in 1..16");
   end endgenerate

   logic wr_ctrl, wr_data, wr_lo, wr_hi;
   assign wr_ctrl = bus_we && (bus_addr == 2'(OFS_CTRL));
   assign wr_data = bus_we && (bus_addr == 2'(OFS_DATA));
   assign wr_lo   = bus_we && (bus_addr == 2'(OFS_ADDR_LO));
   assign wr_hi   = bus_we && (bus_addr == 2'(OFS_ADDR_HI));

   // address register: no reset value
   logic [LO_W-1:0]   lo_q;
   logic [ADDR_W-1:0] cur_addr;
   logic [BUS_W-1:0]  lo_rd, hi_rd;

   always_ff @(posedge clk) begin
      if (wr_lo) lo_q <= bus_wdata[LO_W-1:0];
   end
   assign lo_rd = BUS_W'(lo_q);

   generate if (ADDR_W > 8) begin : g_hi
      logic [ADDR_W-9:0] hi_q;
      always_ff @(posedge clk) begin
         if (wr_hi) hi_q <= bus_wdata[ADDR_W-9:0];
      end
      assign cur_addr = {hi_q, lo_q};
      assign hi_rd    = BUS_W'(hi_q);
      if (ADDR_W < 16) begin : g_hi_unused
         logic unused_hi_bits;
         assign unused_hi_bits = ^bus_wdata[7:ADDR_W-8];
      end
   end else begin : g_no_hi
      assign cur_addr = lo_q;
      assign hi_rd    = '0;
   end endgenerate

   // sequencing
   logic open, busy, commit, start, rd_go;
   logic [ADDR_W-1:0] c_addr;
   logic [BUS_W-1:0]  c_data, arr_rdata;
   logic [BUS_W-1:0]  data_q;
   logic              ien_q;

   assign start = wr_ctrl && bus_wdata[CB_WR] && open && !busy;
   assign rd_go = wr_ctrl && bus_wdata[CB_RD] && !busy;

   nvm_unlock #(.WINDOW(ARM_WINDOW)) u_unlock (
      .clk(clk), .rst_n(rst_n),
      .arm_i(wr_ctrl && bus_wdata[CB_ARM]),
      .open_o(open));

   nvm_prog_seq #(.PROG_CYCLES(PROG_CYCLES), .ADDR_W(ADDR_W), .DATA_W(BUS_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .addr_i(cur_addr), .data_i(data_q),
      .busy_o(busy), .commit_o(commit),
      .commit_addr_o(c_addr), .commit_data_o(c_data));

   nvm_array #(.ADDR_W(ADDR_W), .DATA_W(BUS_W)) u_array (
      .clk(clk), .we_i(commit), .waddr_i(c_addr), .wdata_i(c_data),
      .raddr_i(cur_addr), .rdata_o(arr_rdata));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         ien_q  <= 1'b0;
      end else begin
         if (wr_data)    data_q <= bus_wdata;
         else if (rd_go) data_q <= arr_rdata;
         if (wr_ctrl)    ien_q  <= bus_wdata[CB_IEN];
      end
   end

   logic [BUS_W-1:0] ctrl_rd, mux_rd;
   always_comb begin
      ctrl_rd         = '0;
      ctrl_rd[CB_IEN] = ien_q;
      ctrl_rd[CB_ARM] = open;
      ctrl_rd[CB_WR]  = busy;
      unique case (bus_addr)
         2'(OFS_CTRL):    mux_rd = ctrl_rd;
         2'(OFS_DATA):    mux_rd = data_q;
         2'(OFS_ADDR_LO): mux_rd = lo_rd;
         default:         mux_rd = hi_rd;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_data <= '0;
      else if (bus_re) rd_data <= mux_rd;
   end

   assign irq_o = ien_q && global_ie && !busy;

   // R5: a write command while locked never starts programming
   a_r5_locked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata[CB_WR] && !open && !busy) |=> !busy);
   // R7: interrupt silent during a write
   a_r7_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !irq_o);
   // R10: read command during a write leaves data register alone
   a_r10_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata[CB_RD] && busy) |=> $stable(data_q));
   // R4: accepted write command makes the controller busy
   a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
endmodule

// File: tb/nvm_ctrl_tb.sv
module nvm_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PROG = 64;
   localparam int WIN  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_we = 1'b0, bus_re = 1'b0;
   logic [7:0] rd_data;
   logic       global_ie = 1'b1;
   logic       irq_o;

   int total = 0, bad = 0;
   logic [7:0] ien_bits = 8'h00;

   always #(CLK_PERIOD/2) clk = ~clk;

   nvm_ctrl #(.ADDR_W(9), .PROG_CYCLES(PROG), .ARM_WINDOW(WIN)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .rd_data(rd_data),
      .global_ie(global_ie), .irq_o(irq_o));

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%02h expected=%02h", req, got, exp);
      end
   endtask

   // each bus task uses exactly one clock edge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      d = rd_data;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_addr(input int a);
      wr(2'd2, a[7:0]);
      wr(2'd3, {7'b0, a[8]});
   endtask

   task automatic program_byte(input int a, input logic [7:0] d);
      set_addr(a);
      wr(2'd1, d);
      wr(2'd0, ien_bits | 8'h04);
      wr(2'd0, ien_bits | 8'h02);
      idle(PROG);
   endtask

   task automatic read_byte(input int a, output logic [7:0] d);
      set_addr(a);
      wr(2'd0, ien_bits | 8'h01);
      rd(2'd1, d);
   endtask

   task automatic t_reset;
      logic [7:0] v;
      check("R8 irq after reset", {7'b0, irq_o}, 8'h00);
      rd(2'd0, v); check("R8 ctrl reset", v, 8'h00);
      rd(2'd1, v); check("R8 data reset", v, 8'h00);
   endtask

   task automatic t_reserved;
      logic [7:0] v;
      wr(2'd3, 8'hFF); rd(2'd3, v); check("R1 high byte reserved bits", v, 8'h01);
      wr(2'd2, 8'hAB); rd(2'd2, v); check("R1 low byte", v, 8'hAB);
      wr(2'd0, 8'hF8); rd(2'd0, v); check("R2 ctrl reserved bits", v, 8'h08);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_window;
      logic [7:0] v;
      wr(2'd0, 8'h04);
      rd(2'd0, v); check("R3 armed edge1", v, 8'h04);
      idle(1);
      rd(2'd0, v); check("R3 armed edge3", v, 8'h04);
      rd(2'd0, v); check("R3 armed edge4", v, 8'h04);
      rd(2'd0, v); check("R3 cleared edge5", v, 8'h00);
   endtask

   task automatic t_program;
      logic [7:0] v;
      program_byte(0, 8'h3C);
      program_byte(511, 8'hC3);
      program_byte(256, 8'h81);
      read_byte(0, v);   check("R4 addr 0", v, 8'h3C);
      read_byte(511, v); check("R4 addr 511", v, 8'hC3);
      read_byte(256, v); check("R4 addr 256", v, 8'h81);
      rd(2'd0, v); check("R6 read bit self-clears", v & 8'h01, 8'h00);
      // latest legal edge: command on edge 4 after arming
      set_addr(20); wr(2'd1, 8'h77);
      wr(2'd0, 8'h04); idle(WIN-1); wr(2'd0, 8'h02);
      rd(2'd0, v); check("R9 busy after start", v & 8'h02, 8'h02);
      idle(PROG-2);
      rd(2'd0, v); check("R9 busy on last cycle", v & 8'h02, 8'h02);
      rd(2'd0, v); check("R9 busy cleared", v & 8'h02, 8'h00);
      read_byte(20, v); check("R3 write on last window edge", v, 8'h77);
   endtask

   task automatic t_locked;
      logic [7:0] v;
      program_byte(5, 8'h11);
      set_addr(5); wr(2'd1, 8'h99);
      wr(2'd0, 8'h02);
      rd(2'd0, v); check("R5 no busy without arm", v & 8'h02, 8'h00);
      wr(2'd0, 8'h04); idle(WIN); wr(2'd0, 8'h02);
      rd(2'd0, v); check("R5 command after window", v & 8'h02, 8'h00);
      wr(2'd0, 8'h06);
      rd(2'd0, v); check("R5 arm and command together", v & 8'h02, 8'h00);
      idle(PROG);
      read_byte(5, v); check("R5 array unchanged", v, 8'h11);
   endtask

   task automatic t_irq;
      ien_bits = 8'h08;
      wr(2'd0, ien_bits);
      check("R7 irq enabled idle", {7'b0, irq_o}, 8'h01);
      global_ie = 1'b0; #1;
      check("R7 irq gated globally", {7'b0, irq_o}, 8'h00);
      global_ie = 1'b1;
      set_addr(30); wr(2'd1, 8'h5C);
      wr(2'd0, ien_bits | 8'h04); wr(2'd0, ien_bits | 8'h02);
      check("R7 irq low while writing", {7'b0, irq_o}, 8'h00);
      idle(PROG);
      check("R7 irq back after write", {7'b0, irq_o}, 8'h01);
      ien_bits = 8'h00;
      wr(2'd0, 8'h00);
      check("R7 irq disabled", {7'b0, irq_o}, 8'h00);
   endtask

   task automatic t_busy_protect;
      logic [7:0] v;
      set_addr(7); wr(2'd1, 8'h42);
      wr(2'd0, 8'h04); wr(2'd0, 8'h02);
      wr(2'd2, 8'h08); wr(2'd1, 8'h5A);
      wr(2'd0, 8'h01);
      rd(2'd1, v); check("R10 read ignored while busy", v, 8'h5A);
      idle(PROG);
      read_byte(7, v); check("R11 latched target intact", v, 8'h42);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset;
      t_reserved;
      t_window;
      t_program;
      t_locked;
      t_irq;
      t_busy_protect;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule